// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the target side of a two-wire serial memory. It oversamples the clock line and the open-drain data line with the system clock and spots start and stop conditions. It then matches an 8-bit device address word against a fixed prefix and three strap inputs, and serves byte writes, page writes, current-address reads, random reads and sequential reads from an on-chip byte array. The data line is never driven high: the engine only asserts an output enable that pulls the line low.

Each write transfer that stores at least one byte and ends with a stop opens a self-timed busy window. Its length is a parameter counted in system clock cycles. While the window is open the engine ignores all traffic and acknowledges nothing, so a host can poll for completion by sending device addresses until one is acknowledged. A write-protect input blocks stores to the array. The word pointer is 13 bits wide. The array depth is a parameter, and its default is kept small, so the array index is taken from the pointer's low bits.

Top module: `eeprom_target`

## Requirements
- R1: A device address word matches only when its bits 7..4 are 1,0,1,0 and bits 3..1 equal strap_i[2:0]; bit 0 selects read (1) or write (0).
- R2: On a match the engine pulls data low for the whole ninth clock as an acknowledge. On a mismatch it never drives data and waits for the next start. Out of reset, sda_oe is 0.
- R3: A write-mode transfer carries a high then a low word-address byte after the device address. Only the low 13 bits of the pair are used, and the array is indexed by the low ARRAY_AW bits of that pointer.
- R4: Data falling while clock is high is a start and data rising while clock is high is a stop. A start restarts address matching at any point, and a stop ends any transfer and releases the line.
- R5: Every word-address and data byte of a matched write transfer is acknowledged, and each data byte is stored at the current pointer.
- R6: A stop that ends a write transfer in which at least one byte was stored opens a busy window of BUSY_CYC cycles. During the window no device address is acknowledged.
- R7: After each data byte only the low 5 pointer bits advance, so writes past the end of a 32-byte page wrap to the start of the same page.
- R8: While wp_i is 1, write transfers are still acknowledged byte by byte, but the array is left unchanged and no busy window opens.
- R9: A read-mode device address returns the byte at the current pointer, which is the address after the last byte accessed.
- R10: A write-mode address phase with no data, followed by a repeated start and a read-mode device address, returns the byte at the loaded address.
- R11: In a read, the next byte (pointer plus one, wrapping over the whole array) is sent for every host acknowledge. A host non-acknowledge ends the read.
- R12: Received bits are sampled on the rising clock edge, and sda_oe changes only while the sampled clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 3 | Hardwired device address bits |
| wp_i | input | 1 | Write protect; 1 blocks array stores |

## Verification
The engine sees each bus edge about two and a half system cycles after the host makes it. The bench therefore holds every clock phase for four cycles, reads an acknowledge or a data bit from the wired line at the end of the clock-high phase that carries it, and reads the acknowledge in the ninth high phase after a byte's eighth bit. The busy window is checked by polling straight after the stop. Each poll takes about 136 cycles, so a 300-cycle window has to refuse between one and four polls, and a protected write must refuse none. A monitor on the falling system edge counts any change of sda_oe while the clock input is high.

// File: rtl/eep_pkg.sv
// Shared types for the two-wire EEPROM target engine.
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_RX,     // shifting in a byte from the host
        ST_ACK,    // ninth clock: target acknowledge or pre-load point
        ST_TX,     // shifting out a byte to the host
        ST_RACK    // ninth clock of a read: host acknowledge
    } eep_state_e;

    typedef enum logic [1:0] {
        K_DEV,     // device address word
        K_AHI,     // high word-address byte
        K_ALO,     // low word-address byte
        K_DATA     // data byte to store
    } eep_kind_e;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/eep_line_sampler.sv
// Line sampler: brings scl/sda into the clk domain through SYNC_N stages
// and flags clock edges plus start and stop conditions.
// Assumes the bus is much slower than clk and that both lines idle high.
module eep_line_sampler #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_N:0] scl_p;
    logic [SYNC_N:0] sda_p;
    logic            scl_prev;
    logic            sda_prev;

    // Synchronizer chain with one extra stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_N-1:0], scl_i};
            sda_p <= {sda_p[SYNC_N-1:0], sda_i};
        end
    end

    assign scl_lvl   = scl_p[SYNC_N-1];
    assign sda_lvl   = sda_p[SYNC_N-1];
    assign scl_prev  = scl_p[SYNC_N];
    assign sda_prev  = sda_p[SYNC_N];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep_array.sv
// Byte array: one synchronous write port and one asynchronous read port
// on the same address. Contents are not reset.
module eep_array #(
    parameter int ARRAY_AW = 10
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ARRAY_AW-1:0] addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata
);
    localparam int DEPTH = 1 << ARRAY_AW;

    logic [7:0] mem [DEPTH];

    // Store one byte when the controller strobes a write.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/eep_busy_timer.sv
// Self-timed write window: loads BUSY_CYC on go and counts down to zero.
// busy is high while cycles remain.
module eep_busy_timer #(
    parameter int BUSY_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] left;

    // Down-counter for the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (go)          left <= CW'(BUSY_CYC);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign busy = (left != '0);

    assert_busy_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
endmodule

// File: rtl/eep_proto_ctrl.sv
// Protocol controller: byte framing, device address match, word pointer,
// write strobes, read shifting and acknowledge handling.
// Assumes synchronized level/edge/event inputs from eep_line_sampler and
// an asynchronous array read on mem_addr.
module eep_proto_ctrl
    import eep_pkg::*;
#(
    parameter int WA_W     = 13,
    parameter int ARRAY_AW = 10,
    parameter int PAGE_AW  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_lvl,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic [2:0]          strap_i,
    input  logic                wp_i,
    input  logic                busy_i,
    input  logic [7:0]          rd_data,
    output logic                sda_oe,
    output logic                mem_we,
    output logic [ARRAY_AW-1:0] mem_addr,
    output logic [7:0]          mem_wdata,
    output logic                commit_go
);
    localparam int HI_W = WA_W - 8;

    eep_state_e      state;
    eep_kind_e       kind;
    logic [3:0]      cnt;
    logic [7:0]      shreg;
    logic [WA_W-1:0] ptr;
    logic [WA_W-1:0] page_next;
    logic            tx_next;
    logic            wrote;
    logic            byte_done;
    logic            dev_hit;

    assign byte_done = (state == ST_RX) && scl_fall && (cnt == 4'd8);
    assign dev_hit   = (shreg[7:1] == {DEV_PREFIX, strap_i});
    assign page_next = {ptr[WA_W-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};

    assign mem_addr  = ptr[ARRAY_AW-1:0];
    assign mem_wdata = shreg;
    assign mem_we    = byte_done && (kind == K_DATA) && !wp_i;
    assign commit_go = stop_evt && wrote && !busy_i;

    // Main sequencer: reacts to start/stop first, then to clock edges per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= K_DEV;
            cnt     <= '0;
            shreg   <= '0;
            ptr     <= '0;
            tx_next <= 1'b0;
            wrote   <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (busy_i) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
        end else if (start_evt) begin
            state  <= ST_RX;
            kind   <= K_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && cnt != 4'd8) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end
                    if (byte_done) begin
                        tx_next <= 1'b0;
                        state   <= ST_ACK;
                        sda_oe  <= 1'b1;
                        case (kind)
                            K_DEV: begin
                                if (dev_hit) begin
                                    kind    <= K_AHI;
                                    tx_next <= shreg[0];
                                end else begin
                                    state  <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            K_AHI: begin
                                ptr[WA_W-1:8] <= shreg[HI_W-1:0];
                                kind          <= K_ALO;
                            end
                            K_ALO: begin
                                ptr[7:0] <= shreg;
                                kind     <= K_DATA;
                            end
                            default: begin
                                ptr <= page_next;
                                if (!wp_i) wrote <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (tx_next) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                            cnt    <= 4'd1;
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            state <= ST_IDLE;
                        end else begin
                            state   <= ST_ACK;
                            tx_next <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));
    assert_stop_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
    assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !sda_oe);
endmodule

// File: rtl/eeprom_target.sv
// Two-wire serial EEPROM target: top level joining the line sampler,
// protocol controller, byte array and busy timer.
// Assumes clk runs many times faster than the bus clock.
module eeprom_target #(
    parameter int WA_W     = 13,
    parameter int ARRAY_AW = 10,
    parameter int PAGE_AW  = 5,
    parameter int BUSY_CYC = 300,
    parameter int SYNC_N   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    logic                scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic                start_evt, stop_evt;
    logic                busy, commit_go, mem_we;
    logic [ARRAY_AW-1:0] mem_addr;
    logic [7:0]          mem_wdata, mem_rdata;

    eep_line_sampler #(.SYNC_N(SYNC_N)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    eep_proto_ctrl #(.WA_W(WA_W), .ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
        .stop_evt(stop_evt), .strap_i(strap_i), .wp_i(wp_i), .busy_i(busy),
        .rd_data(mem_rdata), .sda_oe(sda_oe), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .commit_go(commit_go)
    );

    eep_array #(.ARRAY_AW(ARRAY_AW)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    eep_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .go(commit_go), .busy(busy)
    );

    assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));
    assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !mem_we);
endmodule

// File: tb/sim_eeprom_target.sv
`timescale 1ns/1ps
module sim_eeprom_target;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int BUSY  = 300;
    localparam int H     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       sda_line;
    assign sda_line = sda_h & ~sda_oe;

    int checks = 0, errors = 0, viol = 0;
    bit done = 0;
    logic prev_oe = 1'b0;
    logic [7:0]  mdl  [DEPTH];
    bit          mval [DEPTH];
    logic [12:0] mptr = '0;
    logic [7:0]  wbuf [64];

    always #2.5 clk = ~clk;

    eeprom_target #(.ARRAY_AW(AW), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
    );

    // R12 monitor: output enable must not move while the clock input is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev_byte(input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic b_start();
        sda_h = 1'b1; hw(H); scl = 1'b1; hw(H); sda_h = 1'b0; hw(H); scl = 1'b0; hw(H);
    endtask

    task automatic b_stop();
        sda_h = 1'b0; hw(H); scl = 1'b1; hw(H); sda_h = 1'b1; hw(H);
    endtask

    task automatic b_bit(input bit v);
        sda_h = v; hw(H); scl = 1'b1; hw(H); scl = 1'b0; hw(H);
    endtask

    // Send a byte; ack=1 when the target pulled the line low in the ninth clock.
    task automatic b_send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) b_bit(b[i]);
        sda_h = 1'b1; hw(H); scl = 1'b1; hw(H);
        ack = ~sda_line;
        scl = 1'b0; hw(H);
    endtask

    task automatic b_recv(output logic [7:0] d, input bit ack_it);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; hw(H); scl = 1'b1; hw(H);
            d[i] = sda_line;
            scl = 1'b0; hw(H);
        end
        b_bit(~ack_it);
        sda_h = 1'b1;
    endtask

    task automatic wr_txn(input logic [15:0] aw, input int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        b_start();
        b_send(dev_byte(1'b0), a); all_ack &= a;
        b_send(aw[15:8], a);       all_ack &= a;
        b_send(aw[7:0], a);        all_ack &= a;
        mptr = aw[12:0];
        for (int i = 0; i < n; i++) begin
            b_send(wbuf[i], a); all_ack &= a;
            if (!wp) begin
                mdl[mptr[AW-1:0]]  = wbuf[i];
                mval[mptr[AW-1:0]] = 1'b1;
            end
            mptr = {mptr[12:5], mptr[4:0] + 5'd1};
        end
        b_stop();
    endtask

    task automatic poll(output int nacks);
        bit a;
        nacks = 0;
        for (int k = 0; k < 40; k++) begin
            b_start();
            b_send(dev_byte(1'b0), a);
            b_stop();
            if (a) break;
            nacks++;
        end
    endtask

    task automatic rd_txn(input bit rnd, input logic [15:0] aw, input int n, input string req);
        bit a;
        logic [7:0] d;
        if (rnd) begin
            b_start();
            b_send(dev_byte(1'b0), a); chk(a, req, a, 1);
            b_send(aw[15:8], a);
            b_send(aw[7:0], a);
            mptr = aw[12:0];
        end
        b_start();
        b_send(dev_byte(1'b1), a); chk(a, req, a, 1);
        for (int i = 0; i < n; i++) begin
            b_recv(d, i < n - 1);
            if (mval[mptr[AW-1:0]]) chk(d == mdl[mptr[AW-1:0]], req, d, mdl[mptr[AW-1:0]]);
            mptr = mptr + 13'd1;
        end
        b_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit aa;
        int nk;
        void'($urandom(32'd4242));
        hw(5);
        rst_n = 1'b1;
        hw(2);
        chk(sda_oe == 1'b0, "R2 reset releases line", sda_oe, 0);

        // R1/R2: wrong strap, wrong prefix, then a match.
        b_start(); b_send({4'b1010, strap ^ 3'b001, 1'b0}, aa); b_stop();
        chk(!aa, "R1 strap mismatch no ack", aa, 0);
        b_start(); b_send({4'b1011, strap, 1'b0}, aa); b_stop();
        chk(!aa, "R1 prefix mismatch no ack", aa, 0);
        b_start(); b_send(dev_byte(1'b0), aa); b_stop();
        chk(aa, "R2 matching address acked", aa, 1);

        // R5/R6/R10: single byte write, busy polling, random read.
        wbuf[0] = 8'h5A;
        wr_txn(16'h0123, 1, aa);
        chk(aa, "R5 byte write acks", aa, 1);
        poll(nk);
        chk(nk >= 1 && nk <= 4, "R6 busy refuses polls", nk, 2);
        rd_txn(1'b1, 16'h0123, 1, "R10 random read");

        // R9: current address read after a random read.
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_txn(16'h0140, 3, aa);
        chk(aa, "R5 three byte write acks", aa, 1);
        poll(nk);
        rd_txn(1'b1, 16'h0140, 1, "R10 random read of page start");
        rd_txn(1'b0, 16'h0000, 2, "R9 current address read");

        // R7: 34 bytes from offset 30 wrap inside the page.
        for (int i = 0; i < 34; i++) wbuf[i] = 8'(8'hA0 + i);
        wr_txn(16'h001E, 34, aa);
        chk(aa, "R7 page write acks", aa, 1);
        poll(nk);
        rd_txn(1'b1, 16'h0000, 32, "R7 page wrap contents");

        // R3: upper word-address bits ignored; array index from low bits.
        wbuf[0] = 8'hC3;
        wr_txn(16'hE200, 1, aa); poll(nk);
        rd_txn(1'b1, 16'h0200, 1, "R3 top bits ignored");
        wbuf[0] = 8'h3C;
        wr_txn(16'h1010, 1, aa); poll(nk);
        rd_txn(1'b1, 16'h0010, 1, "R3 array index low bits");

        // R11: sequential read across the end of the array.
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        wr_txn(16'h03FE, 2, aa); poll(nk);
        rd_txn(1'b1, 16'h03FE, 4, "R11 sequential rollover");

        // R8: write protect.
        wp = 1'b1;
        wbuf[0] = 8'h99; wbuf[1] = 8'h98;
        wr_txn(16'h0140, 2, aa);
        chk(aa, "R8 protected bytes acked", aa, 1);
        poll(nk);
        chk(nk == 0, "R8 no busy under protect", nk, 0);
        rd_txn(1'b1, 16'h0140, 2, "R8 array unchanged");
        wp = 1'b0;

        // R4: abort mid-byte with a stop, then a normal transfer.
        b_start(); b_bit(1'b1); b_bit(1'b0); b_bit(1'b1); b_stop();
        chk(sda_oe == 1'b0, "R4 stop releases line", sda_oe, 0);
        rd_txn(1'b1, 16'h0141, 1, "R4 transfer after abort");

        // Random mix of page writes and sequential reads.
        for (int it = 0; it < 12; it++) begin
            int len;
            logic [15:0] aw;
            len = 1 + $urandom_range(35);
            aw  = 16'($urandom);
            for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
            wr_txn(aw, len, aa);
            chk(aa, "R5 random write acks", aa, 1);
            poll(nk);
            chk(nk >= 1 && nk <= 4, "R6 random busy window", nk, 2);
            rd_txn(1'b1, aw, 1 + $urandom_range(5), "R11 random sequential read");
        end

        chk(viol == 0, "R12 output changes only with clock low", viol, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule